// File: doc/BRIEF.md
# Nine-bit I2C Word FIFO Pair

This block holds the byte traffic between a register-mapped host port and a bit-serial I2C engine. One queue carries outgoing 9-bit words from the host to the engine. The other carries incoming 9-bit words from the engine back to the host. Each word holds the data byte in bits 8..1 and the acknowledge/release bit in bit 0. A host that writes a byte sets bit 0 to 1. A host that reads a byte shifts the word right by one.

Each queue is eight words deep. Its occupancy appears on a 3-bit level field, which wraps to zero when the queue holds all eight words. Separate flags mark the full and half-full states, so the host can tell an empty queue from a full one. Each queue has its own enable. A soft-reset input empties both queues and clears the sticky error flags. If the receive queue still holds data when the soft reset is asserted, a busy error is raised. Interrupt generation and the bus engine are not part of this block.

Top module: `i2c_word_fifo_pair`

## Requirements
- R1: The transmit queue holds up to 8 words and presents them to the engine in write order. `eng_tx_word` shows the oldest word and `eng_tx_avail` is high whenever the queue is not empty. Every accepted write and every engine pop takes effect at the next rising clock edge.
- R2: `tx_level` and `rx_level` give the number of stored words modulo 8, so they read 0 both when a queue is empty and when it holds 8 words.
- R3: `tx_full` is high while the transmit queue holds 8 words. A host write to a full queue, with no engine pop in the same cycle, is dropped and sets the sticky `tx_ovf` flag.
- R4: `rx_ready` is high exactly while the receive queue holds 8 words.
- R5: `tx_half` and `rx_half` are high while the queue in question holds 4 or more words.
- R6: Words pass through both queues bit-exact, with the byte in bits 8..1 and the acknowledge bit in bit 0. `rx_rdata` shows the oldest received word during a host read, and the read removes that word at the clock edge.
- R7: A host read from an empty, enabled receive queue returns 0 on `rx_rdata` and sets the sticky `rx_unf` flag.
- R8: While a queue's enable is low, that queue is held empty and ignores pushes and pops, and none of its error flags change.
- R9: A soft reset empties both queues and clears `tx_ovf` and `rx_unf`. It sets `busy_err` if the receive queue was not empty at that moment, and clears `busy_err` otherwise.
- R10: A push and a pop in the same cycle are both served. A write to a full transmit queue together with an engine pop is accepted and leaves the queue full, with no overflow. A host read of an empty receive queue together with an engine push returns 0, sets `rx_unf`, and stores the pushed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_en | input | 1 | Transmit queue enable |
| rx_en | input | 1 | Receive queue enable |
| soft_rst | input | 1 | Flush both queues and update the error flags |
| tx_wr | input | 1 | Host write strobe for the transmit queue |
| tx_wdata | input | 9 | Host write word (byte in 8..1, ack in 0) |
| rx_rd | input | 1 | Host read strobe for the receive queue |
| rx_rdata | output | 9 | Oldest received word, or 0 when empty |
| eng_tx_pop | input | 1 | Engine takes the oldest transmit word |
| eng_tx_word | output | 9 | Oldest transmit word |
| eng_tx_avail | output | 1 | Transmit queue not empty |
| eng_rx_push | input | 1 | Engine stores a received word |
| eng_rx_word | input | 9 | Received word from the engine |
| tx_level | output | 3 | Transmit occupancy modulo 8 |
| tx_full | output | 1 | Transmit queue holds 8 words |
| tx_half | output | 1 | Transmit queue holds 4 or more words |
| rx_level | output | 3 | Receive occupancy modulo 8 |
| rx_ready | output | 1 | Receive queue holds 8 words |
| rx_half | output | 1 | Receive queue holds 4 or more words |
| tx_ovf | output | 1 | Sticky: a transmit write was dropped |
| rx_unf | output | 1 | Sticky: a read hit an empty receive queue |
| busy_err | output | 1 | Soft reset found data in the receive queue |

## Verification
The transmit queue can be full in the same cycle that the host writes and the engine pops. This case is provoked by filling the queue, then raising `tx_wr` and `eng_tx_pop` together. It passes if the popped word is the oldest one, the queue stays full with no overflow flag, and the new word comes out last. The mirror case is provoked on an empty receive queue by a host read and an engine push in the same cycle. It passes if the read returns 0 and raises the underflow flag, and the pushed word is still counted and can be read on the next access.

// File: rtl/i2c_word_fifo_pair.sv
module i2c_word_fifo_pair #(
  parameter int DEPTH = 8,
  parameter int WORD_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic              soft_rst,
  input  logic              tx_wr,
  input  logic [WORD_W-1:0] tx_wdata,
  input  logic              rx_rd,
  output logic [WORD_W-1:0] rx_rdata,
  input  logic              eng_tx_pop,
  output logic [WORD_W-1:0] eng_tx_word,
  output logic              eng_tx_avail,
  input  logic              eng_rx_push,
  input  logic [WORD_W-1:0] eng_rx_word,
  output logic [$clog2(DEPTH)-1:0] tx_level,
  output logic              tx_full,
  output logic              tx_half,
  output logic [$clog2(DEPTH)-1:0] rx_level,
  output logic              rx_ready,
  output logic              rx_half,
  output logic              tx_ovf,
  output logic              rx_unf,
  output logic              busy_err
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HALF_C = CNT_W'(DEPTH / 2);
  localparam logic [PTR_W-1:0] LAST_P = PTR_W'(DEPTH - 1);

  logic [WORD_W-1:0] tx_mem [DEPTH];
  logic [WORD_W-1:0] rx_mem [DEPTH];
  logic [PTR_W-1:0]  tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CNT_W-1:0]  tx_cnt, rx_cnt;

  wire tx_live = tx_en & ~soft_rst;
  wire rx_live = rx_en & ~soft_rst;
  wire tx_pop  = tx_live & eng_tx_pop & (tx_cnt != '0);
  wire tx_push = tx_live & tx_wr & ((tx_cnt != FULL_C) | tx_pop);
  wire rx_pop  = rx_live & rx_rd & (rx_cnt != '0);
  wire rx_push = rx_live & eng_rx_push & ((rx_cnt != FULL_C) | rx_pop);

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == LAST_P) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= tx_wdata;
    if (rx_push) rx_mem[rx_wp] <= eng_rx_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else if (!tx_live) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= nxt(tx_wp);
      if (tx_pop)  tx_rp <= nxt(tx_rp);
      tx_cnt <= tx_cnt + CNT_W'(tx_push) - CNT_W'(tx_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (!rx_live) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= nxt(rx_wp);
      if (rx_pop)  rx_rp <= nxt(rx_rp);
      rx_cnt <= rx_cnt + CNT_W'(rx_push) - CNT_W'(rx_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_ovf <= 1'b0; rx_unf <= 1'b0; busy_err <= 1'b0;
    end else if (soft_rst) begin
      tx_ovf <= 1'b0; rx_unf <= 1'b0;
      busy_err <= (rx_cnt != '0);
    end else begin
      if (tx_live & tx_wr & ~tx_push) tx_ovf <= 1'b1;
      if (rx_live & rx_rd & (rx_cnt == '0)) rx_unf <= 1'b1;
    end
  end

  assign rx_rdata     = (rx_cnt != '0) ? rx_mem[rx_rp] : '0;
  assign eng_tx_word  = tx_mem[tx_rp];
  assign eng_tx_avail = (tx_cnt != '0);
  assign tx_level     = tx_cnt[PTR_W-1:0];
  assign rx_level     = rx_cnt[PTR_W-1:0];
  assign tx_full      = (tx_cnt == FULL_C);
  assign rx_ready     = (rx_cnt == FULL_C);
  assign tx_half      = (tx_cnt >= HALF_C);
  assign rx_half      = (rx_cnt >= HALF_C);

  p_drop_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && tx_wr && !eng_tx_pop && tx_en && !soft_rst) |=> (tx_ovf && tx_full));
  p_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt == FULL_C - 1'b1 && eng_rx_push && !rx_rd && rx_en && !soft_rst) |=> rx_ready);
  p_empty_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && rx_cnt == '0 && rx_en && !soft_rst) |=> rx_unf);
  p_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en) |=> (!eng_tx_avail && tx_level == '0 && !tx_full));
  p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (tx_cnt == '0 && rx_cnt == '0 && !tx_ovf && !rx_unf));
  p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst && rx_cnt != '0) |=> busy_err);
  p_full_swap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && tx_wr && eng_tx_pop && tx_en && !soft_rst) |=> (tx_full && $stable(tx_ovf)));
endmodule

// File: tb/i2c_word_fifo_pair_bench.sv
`timescale 1ns/1ps
module i2c_word_fifo_pair_bench;
  logic clk = 0, rst_n = 0;
  logic tx_en = 1, rx_en = 1, soft_rst = 0;
  logic tx_wr = 0, rx_rd = 0, eng_tx_pop = 0, eng_rx_push = 0;
  logic [8:0] tx_wdata = 0, eng_rx_word = 0;
  logic [8:0] rx_rdata, eng_tx_word;
  logic eng_tx_avail, tx_full, tx_half, rx_ready, rx_half, tx_ovf, rx_unf, busy_err;
  logic [2:0] tx_level, rx_level;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  i2c_word_fifo_pair u_i2c_word_fifo_pair (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic host_write(logic [8:0] w);
    @(negedge clk) tx_wr = 1; tx_wdata = w;
    @(negedge clk) tx_wr = 0;
  endtask

  task automatic eng_pop(output logic [8:0] w);
    @(negedge clk) eng_tx_pop = 1; #1 w = eng_tx_word;
    @(negedge clk) eng_tx_pop = 0;
  endtask

  task automatic eng_push(logic [8:0] w);
    @(negedge clk) eng_rx_push = 1; eng_rx_word = w;
    @(negedge clk) eng_rx_push = 0;
  endtask

  task automatic host_read(output logic [8:0] w);
    @(negedge clk) rx_rd = 1; #1 w = rx_rdata;
    @(negedge clk) rx_rd = 0;
  endtask

  task automatic pulse_soft();
    @(negedge clk) soft_rst = 1;
    @(negedge clk) soft_rst = 0;
  endtask

  task automatic t_reset();
    chk("R2 tx level at reset", tx_level, 0);
    chk("R2 rx level at reset", rx_level, 0);
    chk("R1 avail at reset", eng_tx_avail, 0);
    chk("R3 full/ovf at reset", {tx_full, tx_ovf, rx_unf, busy_err}, 0);
    chk("R7 rdata at reset", rx_rdata, 0);
  endtask

  task automatic t_tx_order();
    logic [8:0] w;
    for (int i = 0; i < 8; i++) begin
      host_write({8'hA0 + 8'(i), 1'b1});
      if (i == 2) chk("R5 tx half at 3", tx_half, 0);
      if (i == 3) begin
        chk("R5 tx half at 4", tx_half, 1);
        chk("R2 tx level at 4", tx_level, 4);
      end
    end
    chk("R2 tx level wraps at 8", tx_level, 0);
    chk("R3 tx full at 8", tx_full, 1);
    chk("R3 no ovf yet", tx_ovf, 0);
    host_write(9'h1FF);
    chk("R3 ovf after write to full", tx_ovf, 1);
    chk("R3 still full", tx_full, 1);
    for (int i = 0; i < 8; i++) begin
      eng_pop(w);
      chk("R1 tx order", w, {8'hA0 + 8'(i), 1'b1});
      chk("R6 tx byte field", w >> 1, 8'hA0 + 8'(i));
    end
    chk("R1 avail after drain", eng_tx_avail, 0);
    chk("R3 ovf sticky", tx_ovf, 1);
  endtask

  task automatic t_rx();
    logic [8:0] w;
    for (int i = 0; i < 8; i++) begin
      eng_push({8'h31 + 8'(3 * i), 1'(i % 2)});
      if (i == 6) chk("R4 rx_ready below 8", rx_ready, 0);
    end
    chk("R4 rx_ready at 8", rx_ready, 1);
    chk("R2 rx level wraps", rx_level, 0);
    chk("R5 rx half", rx_half, 1);
    for (int i = 0; i < 8; i++) begin
      host_read(w);
      chk("R6 rx word exact", w, {8'h31 + 8'(3 * i), 1'(i % 2)});
    end
    chk("R4 rx_ready after drain", rx_ready, 0);
    chk("R7 no unf yet", rx_unf, 0);
    host_read(w);
    chk("R7 empty read returns 0", w, 0);
    chk("R7 unf set", rx_unf, 1);
  endtask

  task automatic t_soft();
    eng_push(9'h055); eng_push(9'h0AA);
    pulse_soft();
    chk("R9 busy_err with rx data", busy_err, 1);
    chk("R9 rx flushed", rx_level, 0);
    chk("R9 flags cleared", {tx_ovf, rx_unf}, 0);
    host_write(9'h003);
    pulse_soft();
    chk("R9 tx flushed", eng_tx_avail, 0);
    chk("R9 busy_err cleared", busy_err, 0);
  endtask

  task automatic t_enable();
    logic [8:0] w;
    host_write(9'h011); host_write(9'h013); host_write(9'h015);
    @(negedge clk) tx_en = 0;
    host_write(9'h017);
    chk("R8 tx held empty", {eng_tx_avail, tx_level}, 0);
    chk("R8 no ovf when off", tx_ovf, 0);
    @(negedge clk) tx_en = 1;
    chk("R8 tx empty after re-enable", tx_level, 0);
    @(negedge clk) rx_en = 0;
    eng_push(9'h123);
    host_read(w);
    chk("R8 rx push ignored", rx_level, 0);
    chk("R8 no unf when off", rx_unf, 0);
    @(negedge clk) rx_en = 1;
  endtask

  task automatic t_same_cycle();
    logic [8:0] w;
    for (int i = 0; i < 8; i++) host_write({8'h60 + 8'(i), 1'b1});
    @(negedge clk) tx_wr = 1; tx_wdata = 9'h1E3; eng_tx_pop = 1; #1 w = eng_tx_word;
    @(negedge clk) tx_wr = 0; eng_tx_pop = 0;
    chk("R10 popped oldest", w, {8'h60, 1'b1});
    chk("R10 still full", tx_full, 1);
    chk("R10 no ovf", tx_ovf, 0);
    for (int i = 1; i < 8; i++) eng_pop(w);
    eng_pop(w);
    chk("R10 new word last", w, 9'h1E3);
    @(negedge clk) rx_rd = 1; eng_rx_push = 1; eng_rx_word = 9'h0C5; #1 w = rx_rdata;
    @(negedge clk) rx_rd = 0; eng_rx_push = 0;
    chk("R10 empty read gives 0", w, 0);
    chk("R10 unf set", rx_unf, 1);
    chk("R10 push stored", rx_level, 1);
    host_read(w);
    chk("R10 pushed word readable", w, 9'h0C5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_tx_order();
    t_rx();
    t_soft();
    t_enable();
    pulse_soft();
    t_same_cycle();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule